// File: doc/BRIEF.md
# DRAM Fill Sequencer

This block writes one data value into every location of a DRAM array after power-up, with no processor involvement. A row counter steps through every row for the current column. When the last row has been written, a column counter moves to the next column and the row walk starts again. This continues until every column has been covered.

Each write cycle strobes the row line of every bank together, with write enable held active. The same row and column location is therefore written in all banks at once, using whatever value the board presents on the DRAM data inputs. When the final location is done, the sequencer stops and raises an interrupt. The interrupt stays set until software acknowledges it.

With 8-bit row and column counters and a 100 ns clock, a fill takes 65,536 write cycles of 400 ns each, about 26 ms.

Top module: `dram_fill_seq`

## Requirements
- R1: After reset, busy and irq are low, every bit of ras_n is 1, cas_n is 1 and we_n is 1.
- R2: A start pulse accepted on a clock edge sets busy on that edge and zeroes both counters. The first write cycle begins in the following clock, at row 0 and column 0.
- R3: Each write cycle lasts exactly four clocks, phases 0 to 3. ras_n is high in phases 0 and 1 and low in phases 2 and 3. All BANKS bits of ras_n always carry the same value.
- R4: we_n is 0 in every clock where busy is high, and 1 whenever busy is low.
- R5: In phases 0 to 2 the bus carries the row count, zero-extended to ADDR_W. In phase 3 it carries the column count, zero-extended. cas_n is 0 only in phase 3.
- R6: After each write cycle the row count rises by one. After a cycle on the all-ones row, the row returns to 0 and the column rises by one.
- R7: After the write cycle at all-ones row and all-ones column, busy falls and irq rises on the same edge, and the strobes return to idle. A fill consists of exactly 2^(ROW_W+COL_W) write cycles.
- R8: irq stays high until an irq_ack clock. It is 0 from the clock after that acknowledge.
- R9: A start pulse while irq is high is ignored: busy stays low and the strobes stay idle.
- R10: A start pulse while busy is high is ignored: the fill continues with the same row and column sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a fill (one clock pulse) |
| irq_ack | input | 1 | Clears the completion interrupt |
| addr | output | ADDR_W | Multiplexed row/column address |
| ras_n | output | BANKS | Row strobes, one per bank, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| busy | output | 1 | Fill in progress |
| irq | output | 1 | Fill complete interrupt |

## Verification
The bench runs a complete fill with unequal row and column widths. A row count leaking onto the bus in the column phase, or a column count in a row phase, shows up as a wrong address. Every clock of every write cycle is compared against a per-phase table of strobe levels and address selection. This separates a shifted strobe window from a wrong carry between the counters. A second fill is poked with start part-way through, and a third start is given while the interrupt is pending. These show that neither restarts the counters or the strobes. The end of the fill is checked on the exact clock, which tells an off-by-one terminal count apart from the correct one.

// File: rtl/fill_seq_pkg.sv
package fill_seq_pkg;

  typedef enum logic [1:0] {
    PH_SETUP   = 2'd0,
    PH_PRE     = 2'd1,
    PH_ROWHOLD = 2'd2,
    PH_COLSTB  = 2'd3
  } fill_phase_e;

  // row strobe active in the second half of a write cycle
  function automatic logic row_strobe_on(input fill_phase_e p);
    return (p == PH_ROWHOLD) || (p == PH_COLSTB);
  endfunction

  // column strobe and column address only in the last phase
  function automatic logic col_phase(input fill_phase_e p);
    return p == PH_COLSTB;
  endfunction

  function automatic fill_phase_e phase_next(input fill_phase_e p);
    return fill_phase_e'(p + 2'd1);
  endfunction

endpackage

// File: rtl/fill_phase_gen.sv
module fill_phase_gen
  import fill_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clear,
  input  logic        run,
  output fill_phase_e phase,
  output logic        cyc_end
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      phase <= PH_SETUP;
    else if (clear)
      phase <= PH_SETUP;
    else if (run)
      phase <= phase_next(phase);
  end

  assign cyc_end = run && (phase == PH_COLSTB);

endmodule

// File: rtl/fill_addr_ctr.sv
module fill_addr_ctr #(
  parameter int ROW_W = 8,
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             step,
  output logic [ROW_W-1:0] row,
  output logic [COL_W-1:0] col,
  output logic             row_term,
  output logic             last_pos
);

  localparam logic [ROW_W-1:0] ROW_TERM = '1;
  localparam logic [COL_W-1:0] COL_TERM = '1;

  assign row_term = (row == ROW_TERM);
  assign last_pos = row_term && (col == COL_TERM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row <= '0;
      col <= '0;
    end else if (clear) begin
      row <= '0;
      col <= '0;
    end else if (step) begin
      row <= row + 1'b1;
      if (row_term)
        col <= col + 1'b1;
    end
  end

endmodule

// File: rtl/fill_strobe_drv.sv
module fill_strobe_drv
  import fill_seq_pkg::*;
#(
  parameter int BANKS  = 4,
  parameter int ROW_W  = 8,
  parameter int COL_W  = 8,
  parameter int ADDR_W = 8
) (
  input  logic              active,
  input  fill_phase_e       phase,
  input  logic [ROW_W-1:0]  row,
  input  logic [COL_W-1:0]  col,
  output logic [ADDR_W-1:0] addr,
  output logic [BANKS-1:0]  ras_n,
  output logic              cas_n,
  output logic              we_n
);

  logic ras_on;
  assign ras_on = active && row_strobe_on(phase);

  generate
    for (genvar b = 0; b < BANKS; b++) begin : g_bank
      assign ras_n[b] = !ras_on;
    end
  endgenerate

  assign cas_n = !(active && col_phase(phase));
  assign we_n  = !active;

  always_comb begin
    addr = '0;
    if (col_phase(phase))
      addr[COL_W-1:0] = col;
    else
      addr[ROW_W-1:0] = row;
  end

endmodule

// File: rtl/dram_fill_seq.sv
module dram_fill_seq
  import fill_seq_pkg::*;
#(
  parameter int BANKS  = 4,
  parameter int ROW_W  = 8,
  parameter int COL_W  = 8,
  parameter int ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              irq_ack,
  output logic [ADDR_W-1:0] addr,
  output logic [BANKS-1:0]  ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic              busy,
  output logic              irq
);

  fill_phase_e      phase;
  logic             cyc_end;
  logic [ROW_W-1:0] row;
  logic [COL_W-1:0] col;
  logic             row_term;
  logic             last_pos;
  logic             start_ok;
  logic             fill_done;

  assign start_ok  = start && !busy && !irq;
  assign fill_done = cyc_end && last_pos;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      irq  <= 1'b0;
    end else begin
      if (start_ok)
        busy <= 1'b1;
      else if (fill_done)
        busy <= 1'b0;
      if (fill_done)
        irq <= 1'b1;
      else if (irq_ack)
        irq <= 1'b0;
    end
  end

  fill_phase_gen u_phase (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (start_ok),
    .run     (busy),
    .phase   (phase),
    .cyc_end (cyc_end)
  );

  fill_addr_ctr #(.ROW_W(ROW_W), .COL_W(COL_W)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (start_ok),
    .step     (cyc_end),
    .row      (row),
    .col      (col),
    .row_term (row_term),
    .last_pos (last_pos)
  );

  fill_strobe_drv #(
    .BANKS(BANKS), .ROW_W(ROW_W), .COL_W(COL_W), .ADDR_W(ADDR_W)
  ) u_drv (
    .active (busy),
    .phase  (phase),
    .row    (row),
    .col    (col),
    .addr   (addr),
    .ras_n  (ras_n),
    .cas_n  (cas_n),
    .we_n   (we_n)
  );

endmodule

// File: rtl/fill_seq_chk.sv
module fill_seq_chk #(
  parameter int BANKS = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             irq_ack,
  input logic [BANKS-1:0] ras_n,
  input logic             cas_n,
  input logic             we_n,
  input logic             busy,
  input logic             irq,
  input logic             fill_done
);

  // R3
  ras_banks_same_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_n == '0) || (ras_n == '1));

  // R3
  ras_two_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n[0]) |=> !ras_n[0]);

  // R5
  cas_inside_ras_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cas_n |-> (ras_n == '0));

  // R4
  we_follows_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy == !we_n);

  // R7
  done_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_done |=> (irq && !busy));

  // R8
  irq_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_ack && !fill_done) |=> irq);

  // R9
  start_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !busy) |=> !busy);

  // R2
  start_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !irq) |=> busy);

endmodule

bind dram_fill_seq fill_seq_chk #(.BANKS(BANKS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .irq_ack   (irq_ack),
  .ras_n     (ras_n),
  .cas_n     (cas_n),
  .we_n      (we_n),
  .busy      (busy),
  .irq       (irq),
  .fill_done (fill_done)
);

// File: tb/sim_dram_fill_seq.sv
`timescale 1ns/1ps
module sim_dram_fill_seq;

  localparam int BANKS  = 2;
  localparam int ROW_W  = 2;
  localparam int COL_W  = 3;
  localparam int ADDR_W = 3;
  localparam int ROWS   = 1 << ROW_W;
  localparam int WRITES = 1 << (ROW_W + COL_W);

  // per phase: {ras_n level, cas_n, column selected}
  localparam logic [2:0] PH_TAB [4] = '{3'b110, 3'b110, 3'b010, 3'b001};

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic              irq_ack = 1'b0;
  logic [ADDR_W-1:0] addr;
  logic [BANKS-1:0]  ras_n;
  logic              cas_n;
  logic              we_n;
  logic              busy;
  logic              irq;

  int checks = 0;
  int fails  = 0;

  always #4 clk = !clk;

  dram_fill_seq #(.BANKS(BANKS), .ROW_W(ROW_W), .COL_W(COL_W), .ADDR_W(ADDR_W)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .irq_ack(irq_ack),
    .addr(addr), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .busy(busy), .irq(irq)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_idle(input string req);
    check({req, " ras_n idle"}, int'(ras_n), (1 << BANKS) - 1);
    check({req, " cas_n idle"}, int'(cas_n), 1);
    check({req, " we_n idle"}, int'(we_n), 1);
  endtask

  task automatic pulse_start;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  // walks a whole fill; optional stray start at write poke_k, phase 1
  task automatic run_fill(input int poke_k);
    pulse_start();
    for (int k = 0; k < WRITES; k++) begin
      for (int p = 0; p < 4; p++) begin
        if (k > 0 || p > 0) @(negedge clk);
        start = 1'b0;
        check("R2 busy during fill", int'(busy), 1);
        check("R3 ras_n level", int'(ras_n), PH_TAB[p][2] ? (1 << BANKS) - 1 : 0);
        check("R5 cas_n", int'(cas_n), int'(PH_TAB[p][1]));
        check("R4 we_n active", int'(we_n), 0);
        if (PH_TAB[p][0])
          check(k == poke_k ? "R10 column after stray start" : "R6 column address",
                int'(addr), k / ROWS);
        else
          check(k == poke_k ? "R10 row after stray start" : "R6 row address",
                int'(addr), k % ROWS);
        if (k == poke_k && p == 1) start = 1'b1;
      end
    end
    @(negedge clk);
    check("R7 busy falls after last write", int'(busy), 0);
    check("R7 irq rises after last write", int'(irq), 1);
    check_idle("R7");
  endtask

  initial begin
    #(200000 * 8);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 busy reset", int'(busy), 0);
    check("R1 irq reset", int'(irq), 0);
    check_idle("R1");
    rst_n = 1'b1;
    @(negedge clk);

    run_fill(-1);

    // R8: irq held while not acknowledged
    repeat (5) @(negedge clk);
    check("R8 irq held", int'(irq), 1);

    // R9: start ignored while irq pending
    pulse_start();
    check("R9 busy stays low", int'(busy), 0);
    check_idle("R9");
    @(negedge clk);
    check("R9 busy still low", int'(busy), 0);
    check("R9 ras_n still idle", int'(ras_n), (1 << BANKS) - 1);

    // R8: acknowledge clears irq
    @(negedge clk) irq_ack = 1'b1;
    @(negedge clk) irq_ack = 1'b0;
    check("R8 irq cleared by ack", int'(irq), 0);

    // R10: second fill with a stray start in the middle
    run_fill(5);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule